// File: doc/BRIEF.md
# Directory Read-Exclusive Controller

This block is the directory side of a point-to-point cache coherence fabric for a set of memory lines. For every line it keeps a stable state (Invalid, Shared, Owned or Modified), a 16-bit vector of sharing nodes, the 4-bit ID of the owning node and a blocked flag. Read-exclusive (ownership) requests arrive on a request channel. The controller works out where the data must come from, which is either memory or the current owner. It emits one reply or forward message that carries the number of acknowledgements the requester must collect. In the same cycle it emits one multicast invalidate vector that covers every recorded sharer other than the requester.

After the reply the line stays blocked. It becomes Modified, owned by the requester and with no sharers, only when that same requester sends an exclusive-unblock on a separate channel that is always accepted. Any request that reaches a blocked line is held at the request port (ready low) until the unblock arrives, and is then served. Read-shared requests only add the reader to the sharer list. Memory reads use a simple valid/ready handshake.

Top module: `dir_rdx_ctrl`

## Requirements
- R1: After reset every line is Invalid with no sharers and not blocked. `req_ready` is 1, and `msg_valid`, `inv_valid` and `mem_rd_valid` are 0.
- R2: A read-exclusive (`req_excl`=1) to an Invalid line raises `mem_rd_valid` with `mem_rd_line` equal to the line. It holds both stable until `mem_rd_ready`, and then sends `msg_kind`=0 (data) to the requester with `msg_acks`=0 and no invalidate.
- R3: A read-exclusive to a Shared line reads memory and sends `msg_kind`=0 to the requester. `inv_mask` has bit n set for every recorded sharer n except the requester, and `msg_acks` equals the number of bits set.
- R4: A read-exclusive to a Modified line owned by another node sends `msg_kind`=1 (forward), with `msg_dest` set to the owner and `msg_requester` set to the requester. It issues no memory read, no invalidate and `msg_acks`=0.
- R5: A read-exclusive to an Owned line owned by another node forwards to the owner as in R4. It also invalidates every recorded sharer except the requester and the owner, and `msg_acks` counts them.
- R6: A read-exclusive whose requester is already the owner (Owned or Modified) sends `msg_kind`=2 (grant) to the requester with no memory read. It invalidates the other sharers, and `msg_acks` counts them.
- R7: After a read-exclusive the line stays blocked until an unblock from the same requester. The line then becomes Modified with that requester as owner and an empty sharer list.
- R8: While a line is blocked, a request of either kind to it is held with `req_ready`=0, producing no output. The request is accepted and served once the unblock has been applied.
- R9: An unblock that comes from a node other than the blocking requester, or that names a line that is not blocked, changes nothing.
- R10: A read-shared (`req_excl`=0) is accepted in one cycle and produces no message or memory read. It changes Invalid to Shared and Modified to Owned, and adds the reader to the sharer list unless the reader is the owner.
- R11: `msg_valid` is a one-cycle pulse, and `inv_valid` is asserted only together with it and only when `inv_mask` is non-zero. Without a memory read the reply comes in the first cycle after acceptance. `req_ready` is 0 from acceptance until the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_excl | input | 1 | 1 = read-exclusive, 0 = read-shared |
| req_node | input | 4 | Requesting node ID |
| req_line | input | LINE_W | Line index |
| unb_valid | input | 1 | Exclusive-unblock present (always accepted) |
| unb_node | input | 4 | Node sending the unblock |
| unb_line | input | LINE_W | Line being unblocked |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_line | output | LINE_W | Line read from memory |
| mem_rd_ready | input | 1 | Memory accepts and returns the read |
| msg_valid | output | 1 | Reply or forward message |
| msg_kind | output | 2 | 0 data, 1 forward, 2 grant |
| msg_dest | output | 4 | Destination node of the message |
| msg_requester | output | 4 | Node that issued the request |
| msg_acks | output | 5 | Acknowledgements the requester must collect |
| inv_valid | output | 1 | Invalidate multicast |
| inv_mask | output | 16 | Bit n set: invalidate node n |

## Verification
A corrupted sharer vector or owner ID does not show at the ports right away. It shows at the next read-exclusive to that line, as a wrong `inv_mask`, a wrong `msg_acks`, or a forward to the wrong node or of the wrong kind. The bench therefore follows every state-changing step with a later ownership request on the same line. A lost or stuck blocked flag shows within one cycle at `req_ready`, as a held or released request. Directed stalls place a wrong-node unblock before the correct one to separate the two cases.

// File: rtl/dir_pkg.sv
package dir_pkg;
    localparam int NODES  = 16;
    localparam int NODE_W = $clog2(NODES);
    localparam int ACK_W  = $clog2(NODES + 1);

    typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_O = 2'd2, LS_M = 2'd3} line_st_e;
    typedef enum logic [1:0] {MK_DATA = 2'd0, MK_FWD = 2'd1, MK_GRANT = 2'd2} msg_kind_e;
    typedef enum logic [1:0] {F_IDLE = 2'd0, F_MEM = 2'd1, F_REPLY = 2'd2} fsm_e;

    typedef struct packed {
        line_st_e             st;
        logic [NODES-1:0]     sharers;
        logic [NODE_W-1:0]    owner;
        logic                 busy;
        logic [NODE_W-1:0]    blk_node;
    } dir_entry_t;

    typedef struct packed {
        msg_kind_e            kind;
        logic                 need_mem;
        logic [NODE_W-1:0]    dest;
        logic [NODES-1:0]     inv;
        logic [ACK_W-1:0]     acks;
    } rdx_action_t;

    function automatic logic [ACK_W-1:0] popcnt(input logic [NODES-1:0] v);
        logic [ACK_W-1:0] c;
        c = '0;
        for (int i = 0; i < NODES; i++) c = c + ACK_W'(v[i]);
        return c;
    endfunction

    function automatic logic [NODES-1:0] node_bit(input logic [NODE_W-1:0] n);
        return NODES'(1) << n;
    endfunction
endpackage

// File: rtl/dir_line_store.sv
module dir_line_store
    import dir_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_line,
    output dir_entry_t        rd_entry,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  dir_entry_t        wr_entry,
    input  logic              unb_valid,
    input  logic [NODE_W-1:0] unb_node,
    input  logic [LINE_W-1:0] unb_line
);
    dir_entry_t ent_q [LINES];
    logic       unb_hit;

    assign rd_entry = ent_q[rd_line];
    assign unb_hit  = unb_valid && ent_q[unb_line].busy &&
                      (ent_q[unb_line].blk_node == unb_node);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (wr_en && wr_line == LINE_W'(i)) begin
                    ent_q[i] <= wr_entry;
                end else if (unb_hit && unb_line == LINE_W'(i)) begin
                    ent_q[i].st      <= LS_M;
                    ent_q[i].owner   <= unb_node;
                    ent_q[i].sharers <= '0;
                    ent_q[i].busy    <= 1'b0;
                end
            end
        end
    end

    // R8: the controller never claims a line that is still blocked
    p_claim_free_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ent_q[wr_line].busy);

    // R7: a matching unblock leaves the line Modified and free
    p_unblock_sets_m_r7: assert property (@(posedge clk) disable iff (rst)
        unb_hit |=> (ent_q[$past(unb_line)].st == LS_M) && !ent_q[$past(unb_line)].busy);
endmodule

// File: rtl/dir_rdx_dec.sv
module dir_rdx_dec
    import dir_pkg::*;
(
    input  dir_entry_t        entry,
    input  logic [NODE_W-1:0] req_node,
    input  logic              req_excl,
    output rdx_action_t       act,
    output dir_entry_t        next_entry
);
    logic [NODES-1:0] req_bit;
    logic [NODES-1:0] keep_mask;
    logic             has_owner;
    logic             self_owned;

    always_comb begin
        req_bit    = node_bit(req_node);
        has_owner  = (entry.st == LS_O) || (entry.st == LS_M);
        self_owned = has_owner && (entry.owner == req_node);
        keep_mask  = has_owner ? ~node_bit(entry.owner) : '1;

        act.inv  = entry.sharers & ~req_bit & keep_mask;
        act.acks = popcnt(act.inv);
        if (!has_owner) begin
            act.kind     = MK_DATA;
            act.need_mem = 1'b1;
            act.dest     = req_node;
        end else if (self_owned) begin
            act.kind     = MK_GRANT;
            act.need_mem = 1'b0;
            act.dest     = req_node;
        end else begin
            act.kind     = MK_FWD;
            act.need_mem = 1'b0;
            act.dest     = entry.owner;
        end

        next_entry = entry;
        if (req_excl) begin
            next_entry.busy     = 1'b1;
            next_entry.blk_node = req_node;
        end else begin
            unique case (entry.st)
                LS_I: begin
                    next_entry.st      = LS_S;
                    next_entry.sharers = req_bit;
                end
                LS_S: next_entry.sharers = entry.sharers | req_bit;
                LS_M: if (!self_owned) begin
                    next_entry.st      = LS_O;
                    next_entry.sharers = entry.sharers | req_bit;
                end
                LS_O: if (!self_owned) next_entry.sharers = entry.sharers | req_bit;
                default: next_entry = entry;
            endcase
        end
    end
endmodule

// File: rtl/dir_rdx_ctrl.sv
module dir_rdx_ctrl
    import dir_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_excl,
    input  logic [NODE_W-1:0]     req_node,
    input  logic [LINE_W-1:0]     req_line,
    input  logic                  unb_valid,
    input  logic [NODE_W-1:0]     unb_node,
    input  logic [LINE_W-1:0]     unb_line,
    output logic                  mem_rd_valid,
    output logic [LINE_W-1:0]     mem_rd_line,
    input  logic                  mem_rd_ready,
    output logic                  msg_valid,
    output logic [1:0]            msg_kind,
    output logic [NODE_W-1:0]     msg_dest,
    output logic [NODE_W-1:0]     msg_requester,
    output logic [ACK_W-1:0]      msg_acks,
    output logic                  inv_valid,
    output logic [NODES-1:0]      inv_mask
);
    fsm_e          fsm_q;
    dir_entry_t    cur_entry;
    dir_entry_t    nxt_entry;
    rdx_action_t   act;
    rdx_action_t   act_q;
    logic [NODE_W-1:0] node_q;
    logic [LINE_W-1:0] line_q;
    logic          accept;

    dir_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_line   (req_line),
        .rd_entry  (cur_entry),
        .wr_en     (accept),
        .wr_line   (req_line),
        .wr_entry  (nxt_entry),
        .unb_valid (unb_valid),
        .unb_node  (unb_node),
        .unb_line  (unb_line)
    );

    dir_rdx_dec u_dec (
        .entry      (cur_entry),
        .req_node   (req_node),
        .req_excl   (req_excl),
        .act        (act),
        .next_entry (nxt_entry)
    );

    assign req_ready = (fsm_q == F_IDLE) && !cur_entry.busy;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q  <= F_IDLE;
            act_q  <= '0;
            node_q <= '0;
            line_q <= '0;
        end else begin
            unique case (fsm_q)
                F_IDLE: if (accept && req_excl) begin
                    act_q  <= act;
                    node_q <= req_node;
                    line_q <= req_line;
                    fsm_q  <= act.need_mem ? F_MEM : F_REPLY;
                end
                F_MEM:   if (mem_rd_ready) fsm_q <= F_REPLY;
                F_REPLY: fsm_q <= F_IDLE;
                default: fsm_q <= F_IDLE;
            endcase
        end
    end

    assign mem_rd_valid  = (fsm_q == F_MEM);
    assign mem_rd_line   = line_q;
    assign msg_valid     = (fsm_q == F_REPLY);
    assign msg_kind      = act_q.kind;
    assign msg_dest      = act_q.dest;
    assign msg_requester = node_q;
    assign msg_acks      = act_q.acks;
    assign inv_valid     = msg_valid && (act_q.inv != '0);
    assign inv_mask      = act_q.inv;

    // R11: reply is a single-cycle pulse
    p_reply_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);

    // R11: invalidates only travel with a reply
    p_inv_with_msg_r11: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> msg_valid);

    // R3: the requester is never among the invalidated nodes
    p_inv_skips_req_r3: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !inv_mask[msg_requester]);

    // R4: forward and grant replies skip memory
    p_fwd_no_mem_r4: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind != 2'd0) |-> !$past(mem_rd_valid));

    // R2: memory read request is held stable until taken
    p_mem_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_line)));
endmodule

// File: tb/tb_dir_rdx_ctrl.sv
`timescale 1ns/1ps
module tb_dir_rdx_ctrl;
    localparam int LINES = 16;
    localparam int LW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_excl = 1'b0;
    logic [3:0]  req_node = '0;
    logic [LW-1:0] req_line = '0;
    logic        req_ready;
    logic        unb_valid = 1'b0;
    logic [3:0]  unb_node = '0;
    logic [LW-1:0] unb_line = '0;
    logic        mem_rd_valid, mem_rd_ready = 1'b0;
    logic [LW-1:0] mem_rd_line;
    logic        msg_valid, inv_valid;
    logic [1:0]  msg_kind;
    logic [3:0]  msg_dest, msg_requester;
    logic [4:0]  msg_acks;
    logic [15:0] inv_mask;

    always #2.5 clk = ~clk;

    dir_rdx_ctrl #(.LINES(LINES), .LINE_W(LW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_excl(req_excl), .req_node(req_node), .req_line(req_line),
        .unb_valid(unb_valid), .unb_node(unb_node), .unb_line(unb_line),
        .mem_rd_valid(mem_rd_valid), .mem_rd_line(mem_rd_line), .mem_rd_ready(mem_rd_ready),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dest(msg_dest),
        .msg_requester(msg_requester), .msg_acks(msg_acks),
        .inv_valid(inv_valid), .inv_mask(inv_mask)
    );

    // reference model: 0 I, 1 S, 2 O, 3 M
    logic [1:0]  m_st  [LINES];
    logic [15:0] m_sh  [LINES];
    logic [3:0]  m_own [LINES];
    logic        m_busy[LINES];
    logic [3:0]  m_blk [LINES];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int cnt16(input logic [15:0] v);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic start_req(input bit excl, input logic [3:0] node, input logic [LW-1:0] line);
        @(negedge clk);
        req_valid = 1'b1; req_excl = excl; req_node = node; req_line = line;
        #1;
    endtask

    // waits for acceptance; returns at the negedge right after the accepting edge
    task automatic wait_accept(input string tag);
        int t = 0;
        while (!req_ready && t < 500) begin
            @(negedge clk); #1; t++;
        end
        chk(req_ready, {tag, " accept"}, 0, 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_rdx(input string tag);
        logic [3:0]  node = req_node;
        logic [LW-1:0] line = req_line;
        bit has_own, exp_mem, saw_mem, got;
        logic [1:0]  ekind;
        logic [3:0]  edest;
        logic [15:0] einv;
        int t = 0;
        has_own = (m_st[line] == 2'd2) || (m_st[line] == 2'd3);
        einv = m_sh[line] & ~(16'd1 << node) & (has_own ? ~(16'd1 << m_own[line]) : 16'hFFFF);
        if (!has_own) begin ekind = 2'd0; edest = node; exp_mem = 1'b1; end
        else if (m_own[line] == node) begin ekind = 2'd2; edest = node; exp_mem = 1'b0; end
        else begin ekind = 2'd1; edest = m_own[line]; exp_mem = 1'b0; end
        wait_accept(tag);
        saw_mem = 1'b0; got = 1'b0;
        while (!got && t < 500) begin
            chk(!req_ready, {tag, " R11 ready low while busy"}, req_ready, 0);
            if (msg_valid) begin
                got = 1'b1;
            end else begin
                if (mem_rd_valid) begin
                    saw_mem = 1'b1;
                    chk(mem_rd_line == line, {tag, " R2 mem line"}, mem_rd_line, line);
                    mem_rd_ready = ($urandom % 3 == 0);
                end else begin
                    mem_rd_ready = 1'b0;
                end
                @(negedge clk); t++;
            end
        end
        mem_rd_ready = 1'b0;
        chk(got, {tag, " R11 reply seen"}, got, 1);
        if (!exp_mem) chk(t == 0, {tag, " R11 reply latency"}, t, 0);
        chk(saw_mem == exp_mem, {tag, " R2/R4 memory use"}, saw_mem, exp_mem);
        chk(msg_kind == ekind, {tag, " R4/R6 kind"}, msg_kind, ekind);
        chk(msg_dest == edest, {tag, " R4/R5 dest"}, msg_dest, edest);
        chk(msg_requester == node, {tag, " R4 requester"}, msg_requester, node);
        chk(int'(msg_acks) == cnt16(einv), {tag, " R3/R5 acks"}, msg_acks, cnt16(einv));
        chk(inv_valid == (einv != 0), {tag, " R11 inv_valid"}, inv_valid, einv != 0);
        if (einv != 0) chk(inv_mask == einv, {tag, " R3/R5 inv mask"}, inv_mask, einv);
        m_busy[line] = 1'b1; m_blk[line] = node;
        @(negedge clk);
        chk(!msg_valid && !inv_valid, {tag, " R11 pulse"}, msg_valid, 0);
    endtask

    task automatic do_rdx(input logic [3:0] node, input logic [LW-1:0] line, input string tag);
        start_req(1'b1, node, line);
        finish_rdx(tag);
    endtask

    task automatic do_rds(input logic [3:0] node, input logic [LW-1:0] line, input string tag);
        start_req(1'b0, node, line);
        wait_accept(tag);
        chk(!msg_valid && !mem_rd_valid && req_ready, {tag, " R10 silent"}, msg_valid, 0);
        unique case (m_st[line])
            2'd0: begin m_st[line] = 2'd1; m_sh[line] = 16'd1 << node; end
            2'd1: m_sh[line] |= 16'd1 << node;
            2'd2: if (m_own[line] != node) m_sh[line] |= 16'd1 << node;
            default: if (m_own[line] != node) begin
                m_st[line] = 2'd2; m_sh[line] |= 16'd1 << node;
            end
        endcase
    endtask

    task automatic do_unb(input logic [3:0] node, input logic [LW-1:0] line);
        @(negedge clk);
        unb_valid = 1'b1; unb_node = node; unb_line = line;
        @(negedge clk);
        unb_valid = 1'b0;
        #1;
        if (m_busy[line] && m_blk[line] == node) begin
            m_busy[line] = 1'b0; m_st[line] = 2'd3; m_own[line] = node; m_sh[line] = '0;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < LINES; i++) begin
            m_st[i] = '0; m_sh[i] = '0; m_own[i] = '0; m_busy[i] = 1'b0; m_blk[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(req_ready && !msg_valid && !inv_valid && !mem_rd_valid, "R1 reset outputs", req_ready, 1);

        // R1/R2: fresh line is Invalid, served from memory
        do_rdx(4'd1, 4'd0, "R2 invalid line");
        do_unb(4'd1, 4'd0);
        // R4 and R7: now Modified owned by node 1
        do_rdx(4'd2, 4'd0, "R4 modified line");
        do_unb(4'd2, 4'd0);
        // R10 then R5
        do_rds(4'd3, 4'd0, "R10 read-shared on M");
        do_rds(4'd5, 4'd0, "R10 second reader");
        do_rdx(4'd5, 4'd0, "R5 owned line");
        do_unb(4'd5, 4'd0);
        // R3 shared line
        do_rds(4'd0, 4'd1, "R10 read-shared on I");
        do_rds(4'd4, 4'd1, "R10 add sharer");
        do_rds(4'd7, 4'd1, "R10 add sharer");
        do_rdx(4'd4, 4'd1, "R3 shared line");
        // R8 stall, R9 wrong-node unblock
        start_req(1'b1, 4'd9, 4'd1);
        for (int k = 0; k < 4; k++) begin
            chk(!req_ready && !msg_valid, "R8 held while blocked", req_ready, 0);
            @(negedge clk); #1;
        end
        do_unb(4'd9, 4'd1);
        chk(!req_ready, "R9 wrong-node unblock ignored", req_ready, 0);
        do_unb(4'd4, 4'd1);
        chk(req_ready, "R8 released after unblock", req_ready, 1);
        finish_rdx("R7/R8 served after unblock");
        do_unb(4'd9, 4'd1);
        // R6 owner re-requests
        do_rdx(4'd6, 4'd2, "R2 invalid line 2");
        do_unb(4'd6, 4'd2);
        do_rds(4'd8, 4'd2, "R10 read on M");
        do_rdx(4'd6, 4'd2, "R6 owner upgrade");
        do_unb(4'd6, 4'd2);
        // R9 unblock to a line that is not blocked
        do_unb(4'd1, 4'd3);
        do_rdx(4'd2, 4'd3, "R9 idle-line unblock ignored");
        do_unb(4'd2, 4'd3);

        // constrained random
        for (int it = 0; it < 600; it++) begin
            logic [LW-1:0] ln = LW'($urandom % 6);
            logic [3:0]    nd = 4'($urandom % 16);
            if (m_busy[ln]) begin
                if ($urandom % 4 == 0) do_unb(4'(m_blk[ln] + 4'd1 + 4'($urandom % 15)), ln);
                else do_unb(m_blk[ln], ln);
            end else if ($urandom % 2 == 0) begin
                do_rdx(nd, ln, "R3/R4/R5/R6 random");
            end else begin
                do_rds(nd, ln, "R10 random");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule